// File: doc/BRIEF.md
# Reset Cause Classifier

The classifier reduces a raw five-bit reset status word to one three-bit reason code. It accepts both variants of the status register. The older variant reports a power-on through a capture bit. The newer variant reports a power-on as all zeros and keeps its software bit set across later resets. The newer register cannot record a reset that touched only the PCI buses, so the block keeps its own one-bit PCI marker. A PCI-reset event sets the marker and a power-up event clears it. While the marker is set, it takes precedence over whatever the register holds.

A one-cycle classify strobe samples the status word and the marker as they stand in that cycle. One clock later the block presents the reason code together with a one-cycle valid pulse. The result port has no ready input and so applies no back-pressure. The consumer must take the code in the cycle that valid is high. The code stays on the port until the next classification.

When the marker is clear, the decode applies a fixed priority: remote-console first, then front-panel, then software, then power-on. The software bit counts only when neither higher cause is present, so a stale software bit cannot hide a front-panel or remote-console reset.

Top module: `reset_cause_classifier`

## Requirements
- R1: While reset is asserted and until the first classification, `res_valid` is 0 and `res_code` holds the unknown code 3'd7.
- R2: A `pci_evt` pulse without `pwrup_evt` sets the PCI marker. Every later classification yields the PCI code 3'd4 until a power-up event.
- R3: A `pwrup_evt` clears the PCI marker. When `pci_evt` and `pwrup_evt` are high in the same cycle, the marker ends cleared.
- R4: While the marker is set, the result is 3'd4 for every status value, including values with the remote-console or front-panel bit set.
- R5: With the marker clear, a status with bits 4:1 all zero, or with bit 2 (capture) as the only bit set among bits 4:1, gives power-on 3'd0.
- R6: With the marker clear, and bits 4 and 3 both zero, bit 1 (software) set gives software 3'd1. Bit 2 may also be set.
- R7: With the marker clear, bit 3 (front-panel) set and bit 4 clear gives front-panel 3'd2, whatever bits 2 and 1 hold.
- R8: With the marker clear, bit 4 (remote-console) set gives remote-console 3'd3, whatever bits 3 to 1 hold.
- R9: Status bit 0 never changes the result.
- R10: A strobe in cycle N gives `res_valid` high in cycle N+1 only. The classification uses the marker as it stood before any event in cycle N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| status_word | input | 5 | Raw reset status word from the register |
| pci_evt | input | 1 | One-cycle pulse: a PCI-only reset took place |
| pwrup_evt | input | 1 | One-cycle pulse: power-up, clears the marker |
| classify | input | 1 | One-cycle strobe requesting a classification |
| res_valid | output | 1 | One-cycle pulse, one clock after the strobe |
| res_code | output | 3 | Reason: 0 power-on, 1 software, 2 front-panel, 3 remote-console, 4 PCI, 7 unknown |

## Verification
The bench builds the block with the default five-bit status width. At that width every status value can be swept exhaustively, with the marker both clear and set, so every priority overlap and every value of the don't-care bit 0 is covered. Because the bit positions stay at their default places, the directed cases on the stale software bit, the capture bit and same-cycle event collisions line up with the positions named in the requirements.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int ST_W   = 5;
  localparam int CODE_W = 3;
  localparam int SW_B   = 1;
  localparam int CAP_B  = 2;
  localparam int FP_B   = 3;
  localparam int RC_B   = 4;

  typedef enum logic [CODE_W-1:0] {
    RSN_PWRON  = 3'd0,
    RSN_SOFT   = 3'd1,
    RSN_FRONT  = 3'd2,
    RSN_REMOTE = 3'd3,
    RSN_PCI    = 3'd4,
    RSN_UNK    = 3'd7
  } reason_t;
endpackage

// File: rtl/rcc_flag.sv
module rcc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (clr_i) flag_o <= 1'b0;   // power-up dominates
    else if (set_i) flag_o <= 1'b1;
  end
endmodule

// File: rtl/rcc_decode.sv
module rcc_decode
  import rcc_pkg::*;
#(
  parameter int W = ST_W
) (
  input  logic [W-1:0] status_i,
  input  logic         pci_flag_i,
  output reason_t      code_o
);
  localparam int HI_W = W - 1;

  logic [HI_W-1:0] hi;
  logic [W-1:0]    stripped;

  assign hi = status_i[W-1:1];

  always_comb begin
    stripped = status_i;
    stripped[SW_B] = 1'b0;
    code_o = RSN_UNK;
    if (pci_flag_i) begin
      code_o = RSN_PCI;
    end else begin
      // later checks override earlier ones
      if ((hi == '0) || status_i[CAP_B]) code_o = RSN_PWRON;
      if (status_i[SW_B])                code_o = RSN_SOFT;
      if (stripped[FP_B])                code_o = RSN_FRONT;
      if (stripped[RC_B])                code_o = RSN_REMOTE;
    end
  end
endmodule

// File: rtl/rcc_outreg.sv
module rcc_outreg
  import rcc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    take_i,
  input  reason_t code_i,
  output logic    valid_o,
  output reason_t code_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      code_o  <= RSN_UNK;
    end else begin
      valid_o <= take_i;
      if (take_i) code_o <= code_i;
    end
  end
endmodule

// File: rtl/reset_cause_classifier.sv
module reset_cause_classifier
  import rcc_pkg::*;
#(
  parameter int ST_WIDTH = ST_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ST_WIDTH-1:0] status_word,
  input  logic                pci_evt,
  input  logic                pwrup_evt,
  input  logic                classify,
  output logic                res_valid,
  output logic [CODE_W-1:0]   res_code
);
  logic    pci_flag;
  reason_t dec_code;
  reason_t held_code;

  rcc_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(pci_evt), .clr_i(pwrup_evt), .flag_o(pci_flag)
  );

  rcc_decode #(.W(ST_WIDTH)) u_dec (
    .status_i(status_word), .pci_flag_i(pci_flag), .code_o(dec_code)
  );

  rcc_outreg u_out (
    .clk(clk), .rst_n(rst_n), .take_i(classify), .code_i(dec_code),
    .valid_o(res_valid), .code_o(held_code)
  );

  assign res_code = held_code;
endmodule

// File: rtl/rcc_checker.sv
module rcc_checker
  import rcc_pkg::*;
#(
  parameter int ST_WIDTH = ST_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ST_WIDTH-1:0] status_word,
  input logic                pci_evt,
  input logic                pwrup_evt,
  input logic                classify,
  input logic                res_valid,
  input logic [CODE_W-1:0]   res_code,
  input logic                pci_flag
);
  // R10
  valid_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    classify |=> res_valid);
  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !classify |=> !res_valid);
  // R3
  pwrup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwrup_evt |=> !pci_flag);
  // R2
  pci_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pci_evt && !pwrup_evt) |=> pci_flag);
  // R4
  pci_overrides_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (classify && pci_flag) |=> (res_code == 3'd4));
  // R8
  remote_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (classify && !pci_flag && status_word[RC_B]) |=> (res_code == 3'd3));
  // R7
  front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (classify && !pci_flag && status_word[FP_B] && !status_word[RC_B]) |=> (res_code == 3'd2));
endmodule

bind reset_cause_classifier rcc_checker #(.ST_WIDTH(ST_WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_word(status_word), .pci_evt(pci_evt),
  .pwrup_evt(pwrup_evt), .classify(classify), .res_valid(res_valid),
  .res_code(res_code), .pci_flag(pci_flag)
);

// File: tb/reset_cause_classifier_test.sv
module reset_cause_classifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] status_word = '0;
  logic       pci_evt = 1'b0;
  logic       pwrup_evt = 1'b0;
  logic       classify = 1'b0;
  logic       res_valid;
  logic [2:0] res_code;
  int nvec = 0;
  int nfail = 0;

  always #4 clk = ~clk;

  reset_cause_classifier uut (
    .clk(clk), .rst_n(rst_n), .status_word(status_word), .pci_evt(pci_evt),
    .pwrup_evt(pwrup_evt), .classify(classify), .res_valid(res_valid), .res_code(res_code)
  );

  function automatic logic [2:0] model(input logic mk, input logic [4:0] s);
    if (mk)        return 3'd4;
    else if (s[4]) return 3'd3;
    else if (s[3]) return 3'd2;
    else if (s[1]) return 3'd1;
    else           return 3'd0;
  endfunction

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe, then sample after the capturing edge
  task automatic run_cls(input string req, input logic [4:0] s, input logic [2:0] exp);
    @(negedge clk); status_word = s; classify = 1'b1;
    @(negedge clk); classify = 1'b0;
    check({req, " valid"}, {2'b0, res_valid}, 3'd1);
    check(req, res_code, exp);
  endtask

  task automatic pulse_pci();
    @(negedge clk); pci_evt = 1'b1;
    @(negedge clk); pci_evt = 1'b0;
  endtask

  task automatic pulse_pwrup();
    @(negedge clk); pwrup_evt = 1'b1;
    @(negedge clk); pwrup_evt = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {2'b0, res_valid}, 3'd0);
    check("R1 code in reset", res_code, 3'd7);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 valid after reset", {2'b0, res_valid}, 3'd0);
    check("R1 code after reset", res_code, 3'd7);
  endtask

  task automatic t_basic();
    run_cls("R5 all zero", 5'b00000, 3'd0);
    run_cls("R5 capture only", 5'b00100, 3'd0);
    run_cls("R6 software", 5'b00010, 3'd1);
    run_cls("R6 software with capture", 5'b00110, 3'd1);
    run_cls("R7 front", 5'b01000, 3'd2);
    run_cls("R7 front with stale sw", 5'b01010, 3'd2);
    run_cls("R8 remote", 5'b10000, 3'd3);
    run_cls("R8 remote with stale sw", 5'b10010, 3'd3);
    run_cls("R8 remote over front", 5'b11010, 3'd3);
    run_cls("R9 bit0 software", 5'b00011, 3'd1);
    run_cls("R9 bit0 power-on", 5'b00001, 3'd0);
  endtask

  task automatic t_pulse();
    @(negedge clk); status_word = 5'b01000; classify = 1'b1;
    @(negedge clk); classify = 1'b0;
    check("R10 valid one cycle later", {2'b0, res_valid}, 3'd1);
    @(negedge clk);
    check("R10 valid drops", {2'b0, res_valid}, 3'd0);
    check("R10 code held", res_code, 3'd2);
  endtask

  task automatic t_pci();
    pulse_pci();
    run_cls("R2 pci marker", 5'b00000, 3'd4);
    run_cls("R4 pci over remote", 5'b11111, 3'd4);
    run_cls("R4 pci over front", 5'b01000, 3'd4);
    pulse_pwrup();
    run_cls("R3 cleared by power-up", 5'b01000, 3'd2);
  endtask

  task automatic t_collide();
    @(negedge clk); pci_evt = 1'b1; pwrup_evt = 1'b1;
    @(negedge clk); pci_evt = 1'b0; pwrup_evt = 1'b0;
    run_cls("R3 simultaneous events", 5'b00010, 3'd1);
    // strobe in the same cycle as the pci event uses the old marker
    @(negedge clk); status_word = 5'b10000; classify = 1'b1; pci_evt = 1'b1;
    @(negedge clk); classify = 1'b0; pci_evt = 1'b0;
    check("R10 strobe uses old marker", res_code, 3'd3);
    run_cls("R2 marker set afterwards", 5'b10000, 3'd4);
    pulse_pwrup();
  endtask

  task automatic t_sweep();
    for (int mk = 0; mk < 2; mk++) begin
      if (mk == 1) pulse_pci();
      for (int s = 0; s < 32; s++)
        run_cls("R4-sweep R5 R6 R7 R8 R9", 5'(s), model(mk[0], 5'(s)));
    end
    pulse_pwrup();
  endtask

  initial begin
    #(8 * 100000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_pulse();
    t_pci();
    t_collide();
    t_sweep();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule